// File: doc/BRIEF.md
# ADC Master Serial Readout Controller

This block is the digital sequencer of a successive-approximation converter that acts as the master of a serial link. A start pulse begins a conversion. The block raises a busy flag and times the conversion phase as a fixed number of system clock cycles. When the phase ends, it latches the parallel result from the converter core. It then sends a 16-bit word to the host, most significant bit first. The serial clock is generated inside the block, and a strobe marks the window in which the data bits are valid.

A mode input picks one of two readout timings. In read-after-conversion mode, the word just converted is sent once the conversion phase is over, and busy stays high until the last bit has gone. In read-during-conversion mode, the result of the previous conversion is sent while the new conversion runs, and busy falls as soon as the conversion phase ends. Two separate controls invert the pin polarity of the serial clock and of the strobe. A clock-source select input held high stops the block from driving the serial link, so that an external clock source can own it.

Top module: `adc_serial_master`

## Requirements
- R1: After reset, with both inversion controls at 0, busy, the serial clock, the strobe and the data output are all low.
- R2: A start pulse sampled while busy is low raises busy at that same clock edge. A start pulse sampled while busy is high is ignored: the busy width does not change and no extra frame is sent.
- R3: With the mode input at 0 (read after conversion), no frame starts during the conversion phase. At the edge that ends the conversion phase, CONV_CYCLES cycles after busy rose, the block latches result_i and starts a frame of that word. The bits go out from bit 15 down to bit 0. Each bit is valid at the rising edge of the non-inverted serial clock, and the data changes only on falling edges.
- R4: In mode 0, busy stays high for CONV_CYCLES + 32*HALF_DIV cycles, which covers the whole frame.
- R5: With the mode input at 1 (read during conversion), the frame starts at the same edge where busy rises. It carries the result latched by the previous conversion, which is zero if no conversion has happened since reset.
- R6: In mode 1, busy stays high for exactly CONV_CYCLES cycles.
- R7: Within a frame, each bit spends HALF_DIV cycles with the serial clock low and then HALF_DIV cycles with it high. The strobe stays asserted for exactly 32*HALF_DIV cycles per frame.
- R8: Outside a frame, the serial clock pin equals inv_sclk_i, the strobe pin equals inv_sync_i (deasserted), and the data pin is low.
- R9: With inv_sclk_i at 1, the serial clock pin is inverted, so bits are valid at its falling edges. With inv_sync_i at 1, the strobe is active low. The frame contents and timing are unchanged in both cases.
- R10: While ext_sel_i is 1, the serial clock pin does not toggle, the strobe stays deasserted and the data pin stays low. The conversion and the result latch still run, so a later mode-1 frame delivers that result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion start request |
| mode_i | input | 1 | 0 = send the new result after conversion, 1 = send the previous result during conversion; sampled when a start is accepted |
| ext_sel_i | input | 1 | Clock-source select; 1 stops the block from driving the serial link |
| inv_sclk_i | input | 1 | Inverts the serial clock pin |
| inv_sync_i | input | 1 | Inverts the strobe pin |
| result_i | input | 16 | Parallel result from the converter core |
| busy_o | output | 1 | Conversion (and, in mode 0, transfer) in progress |
| sclk_o | output | 1 | Serial clock |
| sync_o | output | 1 | Frame strobe, marks valid serial data |
| sdata_o | output | 1 | Serial data, MSB first |

## Verification
Busy rises at the edge that accepts a start. It falls CONV_CYCLES edges later in mode 1, and CONV_CYCLES + 32*HALF_DIV edges later in mode 0. The bench measures the busy width by counting falling clock edges. In mode 1 the strobe must already be active at the first falling edge after the start, and in mode 0 it must still be idle there. Within a frame, bit k counted from the MSB must show its rising serial clock HALF_DIV + 1 + 2*HALF_DIV*k falling edges after the strobe became active, and the monitor checks that position for every bit. A driver task queues the expected word for each frame, choosing between the new and the previous result by mode. A monitor samples at falling clock edges, so it never races the rising edge that updates the design, and compares each word against the queue.

// File: rtl/adcm_pkg.sv
package adcm_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_CONV  = 2'd1,
    SEQ_DRAIN = 2'd2
  } seq_state_t;
endpackage

// File: rtl/adcm_conv_seq.sv
module adcm_conv_seq #(
  parameter int unsigned CONV_CYCLES = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic mode_i,
  input  logic xfer_done_i,
  output logic busy_o,
  output logic mode_q_o,
  output logic accept_o,
  output logic conv_end_o
);
  import adcm_pkg::*;

  localparam int unsigned CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(CONV_CYCLES - 1);

  seq_state_t state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic mode_q, mode_d;
  logic cnt_en;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    mode_d     = mode_q;
    accept_o   = 1'b0;
    conv_end_o = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          mode_d   = mode_i;
          cnt_d    = '0;
          state_d  = SEQ_CONV;
        end
      end
      SEQ_CONV: begin
        if (cnt_q == CNT_LAST) begin
          conv_end_o = 1'b1;
          state_d    = mode_q ? SEQ_IDLE : SEQ_DRAIN;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_DRAIN: begin
        if (xfer_done_i) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  assign cnt_en = (state_q == SEQ_CONV) || accept_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en)   cnt_q  <= cnt_d;
      if (accept_o) mode_q <= mode_d;
    end
  end

  assign busy_o   = (state_q != SEQ_IDLE);
  assign mode_q_o = mode_q;
endmodule

// File: rtl/adcm_shifter.sv
module adcm_shifter #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              active_o,
  output logic              sclk_o,
  output logic              bit_o,
  output logic              done_o
);
  localparam int unsigned DIVW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int unsigned BCW  = $clog2(DATA_W);
  localparam logic [DIVW-1:0] DIV_LAST = DIVW'(HALF_DIV - 1);
  localparam logic [BCW-1:0]  BIT_LAST = BCW'(DATA_W - 1);

  logic              active_q, active_d;
  logic              sclk_q, sclk_d;
  logic [DIVW-1:0]   div_q, div_d;
  logic [BCW-1:0]    bit_q, bit_d;
  logic [DATA_W-1:0] sreg_q, sreg_d;
  logic              tick, run_en;

  assign tick   = active_q && (div_q == DIV_LAST);
  assign done_o = tick && sclk_q && (bit_q == BIT_LAST);
  assign run_en = load_i || active_q;

  always_comb begin
    active_d = active_q;
    sclk_d   = sclk_q;
    div_d    = div_q;
    bit_d    = bit_q;
    sreg_d   = sreg_q;
    if (load_i) begin
      active_d = 1'b1;
      sclk_d   = 1'b0;
      div_d    = '0;
      bit_d    = '0;
      sreg_d   = data_i;
    end else if (active_q) begin
      if (tick) begin
        div_d = '0;
        if (!sclk_q) begin
          sclk_d = 1'b1;
        end else begin
          sclk_d = 1'b0;
          if (bit_q == BIT_LAST) begin
            active_d = 1'b0;
          end else begin
            bit_d  = bit_q + 1'b1;
            sreg_d = {sreg_q[DATA_W-2:0], 1'b0};
          end
        end
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      sreg_q   <= '0;
    end else if (run_en) begin
      active_q <= active_d;
      sclk_q   <= sclk_d;
      div_q    <= div_d;
      bit_q    <= bit_d;
      sreg_q   <= sreg_d;
    end
  end

  assign active_o = active_q;
  assign sclk_o   = sclk_q;
  assign bit_o    = active_q & sreg_q[DATA_W-1];
endmodule

// File: rtl/adcm_pin_stage.sv
module adcm_pin_stage (
  input  logic active_i,
  input  logic sclk_raw_i,
  input  logic bit_i,
  input  logic ext_sel_i,
  input  logic inv_sclk_i,
  input  logic inv_sync_i,
  output logic sclk_o,
  output logic sync_o,
  output logic sdata_o
);
  logic drive;

  assign drive   = active_i & ~ext_sel_i;
  assign sclk_o  = (drive & sclk_raw_i) ^ inv_sclk_i;
  assign sync_o  = drive ^ inv_sync_i;
  assign sdata_o = drive & bit_i;
endmodule

// File: rtl/adc_serial_master.sv
module adc_serial_master #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CONV_CYCLES = 80,
  parameter int unsigned HALF_DIV    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              ext_sel_i,
  input  logic              inv_sclk_i,
  input  logic              inv_sync_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              sync_o,
  output logic              sdata_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_n_sync;
  logic              accept, conv_end, mode_q, xfer_done;
  logic              xfer_active, sclk_raw, xfer_bit;
  logic              load;
  logic [DATA_W-1:0] result_q;
  logic [DATA_W-1:0] load_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe_q[1];

  adcm_conv_seq #(.CONV_CYCLES(CONV_CYCLES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .xfer_done_i(xfer_done),
    .busy_o     (busy_o),
    .mode_q_o   (mode_q),
    .accept_o   (accept),
    .conv_end_o (conv_end)
  );

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)   result_q <= '0;
    else if (conv_end) result_q <= result_i;
  end

  assign load      = (conv_end & ~mode_q) | (accept & mode_i);
  assign load_word = conv_end ? result_i : result_q;

  adcm_shifter #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .load_i  (load),
    .data_i  (load_word),
    .active_o(xfer_active),
    .sclk_o  (sclk_raw),
    .bit_o   (xfer_bit),
    .done_o  (xfer_done)
  );

  adcm_pin_stage u_pins (
    .active_i  (xfer_active),
    .sclk_raw_i(sclk_raw),
    .bit_i     (xfer_bit),
    .ext_sel_i (ext_sel_i),
    .inv_sclk_i(inv_sclk_i),
    .inv_sync_i(inv_sync_i),
    .sclk_o    (sclk_o),
    .sync_o    (sync_o),
    .sdata_o   (sdata_o)
  );
endmodule

// File: rtl/adcm_checker.sv
module adcm_checker #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CONV_CYCLES = 80,
  parameter int unsigned HALF_DIV    = 2
) (
  input logic clk,
  input logic rst_n_sync,
  input logic start_i,
  input logic ext_sel_i,
  input logic inv_sclk_i,
  input logic inv_sync_i,
  input logic busy_o,
  input logic sclk_o,
  input logic sync_o,
  input logic sdata_o,
  input logic mode_q,
  input logic xfer_active,
  input logic sclk_raw
);
  localparam int unsigned LONG_W = CONV_CYCLES + 2 * HALF_DIV * DATA_W;
  localparam int unsigned BW     = $clog2(LONG_W + 2);

  logic [BW-1:0] busy_cnt_q;

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)  busy_cnt_q <= '0;
    else if (busy_o)  busy_cnt_q <= busy_cnt_q + 1'b1;
    else              busy_cnt_q <= '0;
  end

  // R2
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(busy_o) |-> $past(start_i));

  // R4
  busy_covers_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (xfer_active && !mode_q) |-> busy_o);

  // R4
  busy_width_long_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ($fell(busy_o) && !mode_q) |-> (busy_cnt_q == BW'(LONG_W)));

  // R6
  busy_width_short_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ($fell(busy_o) && mode_q) |-> (busy_cnt_q == BW'(CONV_CYCLES)));

  // R7
  sclk_idle_raw_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !xfer_active |-> !sclk_raw);

  // R8
  data_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (sync_o == inv_sync_i) |-> !sdata_o);

  // R10
  ext_sclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (ext_sel_i && $past(ext_sel_i) && $stable(inv_sclk_i)) |-> $stable(sclk_o));
endmodule

bind adc_serial_master adcm_checker #(
  .DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES), .HALF_DIV(HALF_DIV)
) u_chk (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .start_i    (start_i),
  .ext_sel_i  (ext_sel_i),
  .inv_sclk_i (inv_sclk_i),
  .inv_sync_i (inv_sync_i),
  .busy_o     (busy_o),
  .sclk_o     (sclk_o),
  .sync_o     (sync_o),
  .sdata_o    (sdata_o),
  .mode_q     (mode_q),
  .xfer_active(xfer_active),
  .sclk_raw   (sclk_raw)
);

// File: tb/adc_serial_master_test.sv
module adc_serial_master_test;
  localparam int CONV  = 80;
  localparam int HALF  = 2;
  localparam int W     = 16;
  localparam int FRAME = 2 * HALF * W;

  logic clk, rst_n, start_i, mode_i, ext_sel_i, inv_sclk_i, inv_sync_i;
  logic [W-1:0] result_i;
  logic busy_o, sclk_o, sync_o, sdata_o;

  adc_serial_master #(.DATA_W(W), .CONV_CYCLES(CONV), .HALF_DIV(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .ext_sel_i(ext_sel_i), .inv_sclk_i(inv_sclk_i), .inv_sync_i(inv_sync_i),
    .result_i(result_i), .busy_o(busy_o), .sclk_o(sclk_o), .sync_o(sync_o),
    .sdata_o(sdata_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] latched = '0;

  wire sclk_n   = sclk_o ^ inv_sclk_i;
  wire sync_act = sync_o ^ inv_sync_i;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // monitor / scoreboard
  bit           prev_sclk = 0, prev_act = 0, prev_pin = 0;
  int           nbits = 0, since = 0, frames = 0, idle_viol = 0, toggles = 0;
  int           pos_err = 0;
  logic [W-1:0] word = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk_o != prev_pin) toggles++;
      prev_pin = sclk_o;
      if (sync_act) begin
        since++;
        if (sclk_n && !prev_sclk) begin
          if (since != HALF + 1 + 2 * HALF * nbits) pos_err++;
          word = {word[W-2:0], sdata_o};
          nbits++;
          if (nbits == W) begin
            frames++;
            if (exp_q.size() == 0)
              check(0, "R3 or R5 unexpected frame", word, 0);
            else begin
              logic [W-1:0] e;
              e = exp_q.pop_front();
              check(word == e, "R3 or R5 frame word", word, e);
            end
          end
        end
      end else begin
        if (sclk_n || sdata_o) idle_viol++;
        if (prev_act) begin
          check(since == FRAME, "R7 strobe length", since, FRAME);
          check(pos_err == 0, "R7 clock edge positions", pos_err, 0);
        end
        since = 0; nbits = 0; pos_err = 0;
      end
      prev_sclk = sclk_n;
      prev_act  = sync_act;
    end
  end

  task automatic run_conv(input bit md, input logic [W-1:0] val, input bit push,
                          output int w, output bit act0);
    @(negedge clk);
    mode_i = md; result_i = val; start_i = 1'b1;
    if (push) exp_q.push_back(md ? latched : val);
    @(negedge clk);
    start_i = 1'b0;
    act0 = sync_act;
    check(busy_o == 1'b1, "R2 busy rises at accepting edge", busy_o, 1);
    w = 0;
    while (busy_o) begin w++; @(negedge clk); end
    latched = val;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int w; bit a0; int fr;
    rst_n = 0; start_i = 0; mode_i = 0; ext_sel_i = 0;
    inv_sclk_i = 0; inv_sync_i = 0; result_i = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check({busy_o, sclk_o, sync_o, sdata_o} == 4'b0000, "R1 reset outputs",
          {busy_o, sclk_o, sync_o, sdata_o}, 0);

    // mode 1 first after reset: previous result is zero
    run_conv(1, 16'h1234, 1, w, a0);
    check(w == CONV, "R6 busy width mode 1", w, CONV);
    check(a0 == 1'b1, "R5 frame starts with busy", a0, 1);

    // mode 0 patterns
    foreach (pat_list[i]) begin
      run_conv(0, pat_list[i], 1, w, a0);
      check(w == CONV + FRAME, "R4 busy width mode 0", w, CONV + FRAME);
      check(a0 == 1'b0, "R3 no frame during conversion", a0, 0);
    end

    run_conv(1, 16'h5A5A, 1, w, a0);
    check(w == CONV, "R6 busy width mode 1 repeat", w, CONV);

    // inversion
    @(negedge clk); inv_sclk_i = 1; inv_sync_i = 1;
    @(negedge clk);
    check({sclk_o, sync_o, sdata_o} == 3'b110, "R8 idle pins inverted",
          {sclk_o, sync_o, sdata_o}, 3'b110);
    fr = frames;
    run_conv(0, 16'h3C96, 1, w, a0);
    run_conv(1, 16'h0F0F, 1, w, a0);
    check(frames == fr + 2, "R9 frames decoded with inversion", frames, fr + 2);
    @(negedge clk); inv_sclk_i = 0; inv_sync_i = 0;

    // start while busy ignored
    fr = frames;
    fork
      run_conv(0, 16'h7E81, 1, w, a0);
      begin
        repeat (20) @(negedge clk); start_i = 1; @(negedge clk); start_i = 0;
        repeat (80) @(negedge clk); start_i = 1; @(negedge clk); start_i = 0;
      end
    join
    check(w == CONV + FRAME, "R2 busy width with ignored starts", w, CONV + FRAME);
    check(frames == fr + 1, "R2 single frame with ignored starts", frames, fr + 1);
    repeat (10) @(negedge clk);
    check(busy_o == 1'b0, "R2 no extra conversion", busy_o, 0);

    // external clock source
    @(negedge clk); ext_sel_i = 1;
    fr = frames; toggles = 0;
    run_conv(0, 16'hC001, 0, w, a0);
    check(toggles == 0, "R10 sclk quiet", toggles, 0);
    check(frames == fr, "R10 no frame sent", frames, fr);
    check(w == CONV + FRAME, "R10 busy still timed", w, CONV + FRAME);
    @(negedge clk); ext_sel_i = 0;
    run_conv(1, 16'h1111, 1, w, a0);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R3 or R5 all frames received", exp_q.size(), 0);
    check(idle_viol == 0, "R8 idle levels", idle_viol, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  logic [W-1:0] pat_list [4] = '{16'hA5C3, 16'hFFFF, 16'h0001, 16'h8000};
endmodule